// File: doc/BRIEF.md
# USB Function Address Token Filter

This block decides whether a decoded USB token belongs to this device. Software programs an 8-bit function-address register. The low seven bits hold the device address and the top bit enables address matching. An upstream token decoder presents each token as a one-cycle strobe that carries the token's 7-bit address and 4-bit endpoint number. The block answers with a one-cycle accept pulse on the following clock.

A separate input, the endpoint-zero default control, lets endpoint 0 answer at the default address 0 while it is high. This holds even before an address has been enabled, which is the situation during bus enumeration. The stored register is judged as it was before any write in the same cycle, so a reprogrammed address applies from the next token on.

Top module: `usb_addr_filter`

## Requirements
- R1: While reset is asserted and after it is released, the register reads 0x00 and the accept output is low.
- R2: With register bit 7 set, a token whose 7-bit address equals register bits 6..0 is accepted, for any endpoint number; any other address is rejected unless R4 applies.
- R3: With register bit 7 clear and the default control low, no token is accepted, whatever its address or endpoint.
- R4: With the default control high, a token to endpoint 0 at address 0 is accepted whatever the register holds; a token at address 0 to any other endpoint gets no help from the default control.
- R5: The accept output rises only in the cycle right after a token strobe, and lasts one cycle for a one-cycle strobe.
- R6: A register write in the same cycle as a token strobe does not affect that token; the next token sees the new value.
- R7: A read returns the last byte written, bit for bit, with the enable in bit 7 and the address in bits 6..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe for the function-address register |
| regWrData | input | 8 | Write data: bit 7 enable, bits 6..0 address |
| regRdData | output | 8 | Current register value |
| ep0DefaultEn | input | 1 | Lets endpoint 0 answer at the default address |
| tokValid | input | 1 | One-cycle strobe for a decoded token |
| tokAddr | input | 7 | Address field of the token |
| tokEndp | input | 4 | Endpoint field of the token |
| tokAccept | output | 1 | One-cycle pulse: token is for this device |

## Verification
On every cycle the assertions check four things:
- An accept pulse is always preceded by a token strobe.
- An accepted token either matched the stored address with the enable set, or was an endpoint-0, address-0 token with the default control high.
- Write data shows up on the read port one cycle later.
- Reset clears both the register and the accept output.

The assertions cannot show that an accept is missing when it is due, or that a write in the same cycle as a token leaves that token alone. The bench's vector walk and its directed tests cover both.

// File: rtl/usb_addr_filter_pkg.sv
package usb_addr_filter_pkg;
  localparam int ADDR_W = 7;
  localparam int ENDP_W = 4;
  localparam int REG_W  = ADDR_W + 1;

  typedef struct packed {
    logic regLoad;
    logic cmpEn;
  } ctlStrobes_t;
endpackage

// File: rtl/usb_addr_filter_dp.sv
module usb_addr_filter_dp
  import usb_addr_filter_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int EW = ENDP_W,
  parameter logic [AW-1:0] DEFAULT_ADDR = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   strobes,
  input  logic [AW:0]   wrData,
  input  logic          defEn,
  input  logic [AW-1:0] tokAddr,
  input  logic [EW-1:0] tokEndp,
  output logic [AW:0]   regValue,
  output logic          hit
);
  localparam int EN_BIT = AW;

  logic [AW:0] addrReg;
  logic        addrMatch;
  logic        defMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrReg <= '0;
    else if (strobes.regLoad) addrReg <= wrData;
  end

  // The compare uses the value held before this cycle's write.
  always_comb begin
    addrMatch = addrReg[EN_BIT] && (tokAddr == addrReg[AW-1:0]);
    defMatch  = defEn && (tokAddr == DEFAULT_ADDR) && (tokEndp == '0);
    hit       = addrMatch || defMatch;
  end

  assign regValue = addrReg;
endmodule

// File: rtl/usb_addr_filter_ctl.sv
module usb_addr_filter_ctl
  import usb_addr_filter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        tokValid,
  input  logic        hit,
  output ctlStrobes_t strobes,
  output logic        accept
);
  logic acceptQ;

  always_comb begin
    strobes.regLoad = regWrEn;
    strobes.cmpEn   = tokValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acceptQ <= 1'b0;
    else       acceptQ <= strobes.cmpEn && hit;
  end

  assign accept = acceptQ;
endmodule

// File: rtl/usb_addr_filter.sv
module usb_addr_filter
  import usb_addr_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              ep0DefaultEn,
  input  logic              tokValid,
  input  logic [ADDR_W-1:0] tokAddr,
  input  logic [ENDP_W-1:0] tokEndp,
  output logic              tokAccept
);
  ctlStrobes_t strobes;
  logic        hit;

  usb_addr_filter_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .tokValid (tokValid),
    .hit      (hit),
    .strobes  (strobes),
    .accept   (tokAccept)
  );

  usb_addr_filter_dp #(
    .AW (ADDR_W),
    .EW (ENDP_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (regWrData),
    .defEn    (ep0DefaultEn),
    .tokAddr  (tokAddr),
    .tokEndp  (tokEndp),
    .regValue (regRdData),
    .hit      (hit)
  );
endmodule

// File: rtl/usb_addr_filter_chk.sv
module usb_addr_filter_chk
  import usb_addr_filter_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_W-1:0]  regWrData,
  input logic [REG_W-1:0]  regRdData,
  input logic              ep0DefaultEn,
  input logic              tokValid,
  input logic [ADDR_W-1:0] tokAddr,
  input logic [ENDP_W-1:0] tokEndp,
  input logic              tokAccept
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |-> (regRdData == '0 && !tokAccept));

  p_pulse_after_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    tokAccept |-> $past(tokValid));

  p_enable_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    tokAccept |-> ($past(regRdData[REG_W-1]) || $past(ep0DefaultEn)));

  p_addr_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tokAccept && !$past(ep0DefaultEn)) |-> ($past(tokAddr) == $past(regRdData[ADDR_W-1:0])));

  p_default_only_ep0_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tokAccept && !$past(regRdData[REG_W-1])) |-> ($past(tokAddr) == '0 && $past(tokEndp) == '0));

  p_readback_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWrEn) |-> (regRdData == $past(regWrData)));
endmodule

bind usb_addr_filter usb_addr_filter_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regWrEn      (regWrEn),
  .regWrData    (regWrData),
  .regRdData    (regRdData),
  .ep0DefaultEn (ep0DefaultEn),
  .tokValid     (tokValid),
  .tokAddr      (tokAddr),
  .tokEndp      (tokEndp),
  .tokAccept    (tokAccept)
);

// File: tb/usb_addr_filter_tb.sv
module usb_addr_filter_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 12;

  typedef struct packed {
    logic [7:0] regVal;
    logic       defEn;
    logic [6:0] addr;
    logic [3:0] endp;
    logic       expAcc;
  } vec_t;

  // register, default control, token address, token endpoint, expected accept
  localparam vec_t VECS [NVEC] = '{
    '{8'h85, 1'b0, 7'h05, 4'h1, 1'b1},  // R2 match
    '{8'h85, 1'b0, 7'h06, 4'h1, 1'b0},  // R2 mismatch
    '{8'h85, 1'b0, 7'h05, 4'h0, 1'b1},  // R2 endpoint 0
    '{8'h05, 1'b0, 7'h05, 4'h1, 1'b0},  // R3 disabled
    '{8'h05, 1'b0, 7'h00, 4'h0, 1'b0},  // R3 disabled, address 0
    '{8'h00, 1'b1, 7'h00, 4'h0, 1'b1},  // R4 default, enable clear
    '{8'h00, 1'b1, 7'h00, 4'h3, 1'b0},  // R4 other endpoint
    '{8'h85, 1'b1, 7'h00, 4'h0, 1'b1},  // R4 default, enable set
    '{8'h85, 1'b1, 7'h00, 4'h2, 1'b0},  // R4 other endpoint
    '{8'hFF, 1'b0, 7'h7F, 4'hF, 1'b1},  // R2 top address
    '{8'h80, 1'b0, 7'h00, 4'h0, 1'b1},  // R2 enabled at address 0
    '{8'h00, 1'b0, 7'h00, 4'h0, 1'b0}   // R3 all clear
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       ep0DefaultEn = 1'b0;
  logic       tokValid = 1'b0;
  logic [6:0] tokAddr = '0;
  logic [3:0] tokEndp = '0;
  logic       tokAccept;

  int tests = 0;
  int fails = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_addr_filter u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .ep0DefaultEn(ep0DefaultEn), .tokValid(tokValid),
    .tokAddr(tokAddr), .tokEndp(tokEndp), .tokAccept(tokAccept)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] v);
    regWrEn = 1'b1; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Drives a one-cycle token; returns the accept seen one cycle later.
  task automatic sendTok(input logic [6:0] a, input logic [3:0] e, output logic acc);
    tokValid = 1'b1; tokAddr = a; tokEndp = e;
    @(negedge clk);
    tokValid = 1'b0;
    acc = tokAccept;
  endtask

  initial begin
    logic acc;
    @(negedge clk);
    check("R1 reset read", regRdData, 8'h00);
    check("R1 reset accept", {7'b0, tokAccept}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset read", regRdData, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      writeReg(VECS[i].regVal);
      check("R7 readback", regRdData, VECS[i].regVal);
      ep0DefaultEn = VECS[i].defEn;
      sendTok(VECS[i].addr, VECS[i].endp, acc);
      check($sformatf("R2/R3/R4 vector %0d", i), {7'b0, acc}, {7'b0, VECS[i].expAcc});
      @(negedge clk);
      check("R5 pulse ends", {7'b0, tokAccept}, 8'h00);
    end
    ep0DefaultEn = 1'b0;

    // R5: matching address without a strobe gives no accept
    writeReg(8'h9A);
    tokAddr = 7'h1A; tokEndp = 4'h2;
    @(negedge clk);
    @(negedge clk);
    check("R5 no strobe no accept", {7'b0, tokAccept}, 8'h00);

    // R6: write in the same cycle as a token; old value decides
    regWrEn = 1'b1; regWrData = 8'h80;
    tokValid = 1'b1; tokAddr = 7'h1A; tokEndp = 4'h1;
    @(negedge clk);
    regWrEn = 1'b0; tokValid = 1'b0;
    check("R6 old value used (match)", {7'b0, tokAccept}, 8'h01);
    check("R7 new value stored", regRdData, 8'h80);
    sendTok(7'h1A, 4'h1, acc);
    check("R6 next token sees new", {7'b0, acc}, 8'h00);

    regWrEn = 1'b1; regWrData = 8'h03;
    tokValid = 1'b1; tokAddr = 7'h00; tokEndp = 4'h1;
    @(negedge clk);
    regWrEn = 1'b0; tokValid = 1'b0;
    check("R6 old enable still set", {7'b0, tokAccept}, 8'h01);
    sendTok(7'h03, 4'h1, acc);
    check("R6 next token disabled R3", {7'b0, acc}, 8'h00);

    // R7: odd bit pattern
    writeReg(8'h5C);
    check("R7 readback pattern", regRdData, 8'h5C);

    // R1: reset in mid-operation clears state
    writeReg(8'hC4);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset clears register", regRdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule